// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Matrix

This block is a non-blocking digital crosspoint. Every output lane has its own N:1 selector, so any output can take any input and one input can feed any number of outputs at once. The data path from `din` to `dout` is purely combinational through those selectors.

The routing is held in two register banks. A staging bank holds one program entry per output. While `load` is high, the entry chosen by `out_addr` is written with `in_addr` on each clock edge. The staging bank does not affect the data path. While `commit` is high, every staged entry is copied into the active bank at once, and the active bank drives the selectors. This lets a whole new routing be prepared one entry at a time and then take effect on a single edge. Outputs whose selection does not change keep passing data without a glitch.

A pattern input `rst_pat` overwrites both banks. With `commit` low it selects broadcast, where every output takes input 0. With `commit` high it selects pass-through, where output i takes input i. All controls are sampled on the rising edge of `clk`. The active selections can be read back on `active_sel`.

Top module: `xpoint_switch`

## Requirements
- R1: Each output bit `dout[i]` equals `din[k]`, where k is the active selection of output i. It follows `din` combinationally, with no clock delay.
- R2: Both addresses are plain binary indices. `in_addr` value k names input k (0 to 15). `out_addr` value j names the program entry of output j (0 to 15).
- R3: On a clock edge with `load` high and `rst_pat` low, program entry `out_addr` takes the value of `in_addr`. Every other entry, and every entry on edges with `load` low, holds its value.
- R4: Loading program entries without `commit` leaves the active routing and `dout` unchanged.
- R5: On a clock edge with `commit` high and `rst_pat` low, all active selections take their program entries together. With `commit` low, the active selections hold.
- R6: On a clock edge with `rst_pat` high and `commit` low, every program and active entry becomes 0 (broadcast of input 0).
- R7: On a clock edge with `rst_pat` high and `commit` high, entry i of both banks becomes i (pass-through). A later commit with no loads keeps this routing.
- R8: When `rst_pat` and `load` are high on the same edge, the reset pattern wins and the load is discarded.
- R9: `active_sel[4i+3:4i]` carries the active selection of output i.
- R10: When `load` and `commit` are high on the same edge, the commit copies the program contents from before that edge. The new load becomes active only at a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst_pat | input | 1 | Forces the reset pattern into both banks |
| commit | input | 1 | Copies the program bank into the active bank; also picks the reset pattern |
| load | input | 1 | Writes `in_addr` into the program entry chosen by `out_addr` |
| out_addr | input | 4 | Index of the program entry to write |
| in_addr | input | 4 | Index of the source input to store |
| din | input | 16 | Data inputs |
| dout | output | 16 | Data outputs |
| active_sel | output | 64 | Active selections, 4 bits per output |

## Verification
A control applied before a rising edge is reflected in `active_sel` right after that edge. `dout` is combinational from the active bank and `din`, so it is due in the same cycle. The driver sets the inputs on the falling edge and pushes the values expected after the next rising edge. The monitor pops each item 2 ns after that rising edge, before any input changes. A load without a commit is checked by observing that `active_sel` and `dout` stay as they were. The staged value is then shown to surface at a later commit.

// File: rtl/xpoint_switch.sv
module xpoint_switch #(
  parameter int N_PORTS = 16,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst_pat,
  input  logic                       commit,
  input  logic                       load,
  input  logic [SEL_W-1:0]           out_addr,
  input  logic [SEL_W-1:0]           in_addr,
  input  logic [N_PORTS-1:0]         din,
  output logic [N_PORTS-1:0]         dout,
  output logic [N_PORTS*SEL_W-1:0]   active_sel
);

  logic [SEL_W-1:0] prog_q [N_PORTS];
  logic [SEL_W-1:0] act_q  [N_PORTS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_PORTS; i++) begin
      if (rst_pat) begin
        prog_q[i] <= commit ? SEL_W'(i) : '0;
        act_q[i]  <= commit ? SEL_W'(i) : '0;
      end else begin
        if (load && out_addr == SEL_W'(i)) prog_q[i] <= in_addr;
        if (commit) act_q[i] <= prog_q[i];
      end
    end
  end

  logic [N_PORTS*SEL_W-1:0] prog_flat;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
    assign dout[g] = din[act_q[g]];
    assign active_sel[g*SEL_W +: SEL_W] = act_q[g];
    assign prog_flat[g*SEL_W +: SEL_W]  = prog_q[g];
  end

  bit seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst_pat) seen_rst <= 1'b1;

  // R4 and R5: active bank holds unless committed
  a_r5_hold: assert property (@(posedge clk) disable iff (rst_pat)
    seen_rst && !commit |=> active_sel == $past(active_sel));

  // R5 and R10: commit copies the pre-edge program bank
  a_r10_commit: assert property (@(posedge clk) disable iff (rst_pat)
    seen_rst && commit |=> active_sel == $past(prog_flat));

  // R3: the addressed entry takes the input address
  a_r3_load: assert property (@(posedge clk) disable iff (rst_pat)
    seen_rst && load |=> prog_q[$past(out_addr)] == $past(in_addr));

  // R6 and R8: broadcast pattern in both banks, load ignored
  a_r6_broadcast: assert property (@(posedge clk)
    rst_pat && !commit |=> active_sel == '0 && prog_flat == '0);

  // R7: pass-through pattern lands in both banks together
  a_r7_identity: assert property (@(posedge clk)
    rst_pat && commit |=> active_sel == prog_flat && active_sel[SEL_W +: SEL_W] == SEL_W'(1));

endmodule

// File: tb/test_xpoint_switch.sv
module test_xpoint_switch;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_pat = 1'b0, commit = 1'b0, load = 1'b0;
  logic [3:0] out_addr = '0, in_addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [63:0] active_sel;

  xpoint_switch i_xpoint_switch (
    .clk(clk), .rst_pat(rst_pat), .commit(commit), .load(load),
    .out_addr(out_addr), .in_addr(in_addr), .din(din),
    .dout(dout), .active_sel(active_sel));

  typedef struct { logic [63:0] sel; logic [15:0] dat; string tag; } item_t;
  item_t sb_q[$];
  int errors = 0, checks = 0;
  bit [3:0] m_prog [16];
  bit [3:0] m_act  [16];

  task automatic step(input bit r, input bit c, input bit l, input bit [3:0] oa,
                      input bit [3:0] ia, input bit [15:0] d, input string tag);
    item_t it;
    @(negedge clk);
    rst_pat = r; commit = c; load = l; out_addr = oa; in_addr = ia; din = d;
    if (r) begin
      for (int i = 0; i < 16; i++) begin
        m_prog[i] = c ? 4'(i) : 4'd0;
        m_act[i]  = m_prog[i];
      end
    end else begin
      if (c) for (int i = 0; i < 16; i++) m_act[i] = m_prog[i];
      if (l) m_prog[oa] = ia;
    end
    for (int i = 0; i < 16; i++) begin
      it.sel[i*4 +: 4] = m_act[i];
      it.dat[i] = d[m_act[i]];
    end
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (active_sel !== it.sel) begin
          errors++;
          $display("FAIL %s active_sel: actual=%h expected=%h", it.tag, active_sel, it.sel);
        end
        checks++;
        if (dout !== it.dat) begin
          errors++;
          $display("FAIL %s dout: actual=%h expected=%h", it.tag, dout, it.dat);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    // R6 reset state: broadcast of input 0
    step(1, 0, 0, 0, 0, 16'h0001, "R6_broadcast");
    step(0, 0, 0, 0, 0, 16'hFFFE, "R6_input0_low");
    // R3/R4: stage reversed routing, active unchanged
    for (int i = 0; i < 16; i++) step(0, 0, 1, 4'(i), 4'(15 - i), 16'hA5A5, "R4_load_no_effect");
    // R5/R9/R1: commit reversed routing
    step(0, 1, 0, 0, 0, 16'h8001, "R5_commit");
    step(0, 0, 0, 0, 0, 16'h1234, "R1_pattern_a");
    step(0, 0, 0, 0, 0, 16'hF00F, "R1_pattern_b");
    // R2 boundaries: output 0 takes input 15, output 15 takes input 0 (already); multicast input 7
    step(0, 0, 1, 4'd0, 4'd7, 16'h0080, "R2_out0");
    step(0, 0, 1, 4'd15, 4'd7, 16'h0080, "R2_out15");
    step(0, 1, 0, 0, 0, 16'h0080, "R1_multicast_commit");
    step(0, 0, 0, 0, 0, 16'hFF7F, "R1_multicast_low");
    // R10: load and commit on the same edge
    step(0, 1, 1, 4'd3, 4'd9, 16'h0200, "R10_same_edge");
    step(0, 0, 0, 0, 0, 16'h0200, "R10_hold");
    step(0, 1, 0, 0, 0, 16'h0200, "R10_later_commit");
    // R7: pass-through, then a bare commit keeps it
    step(1, 1, 0, 0, 0, 16'h5A3C, "R7_identity");
    step(0, 1, 0, 0, 0, 16'hC3A5, "R7_commit_keeps");
    // R8: reset wins over load
    step(1, 0, 1, 4'd5, 4'd12, 16'h1000, "R8_rst_over_load");
    step(0, 1, 0, 0, 0, 16'h1001, "R8_commit_after");
    step(0, 0, 0, 0, 0, 16'h0000, "R1_all_zero");
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule